// File: doc/BRIEF.md
# Half-Pel Motion Compensation Interpolator

The block builds one 8x8 motion-compensated prediction block from streamed reference pels and can fold the inverse-transform residual into the same pass. A block begins with a start pulse that captures three settings: the interpolation direction (none, vertical or horizontal), a rounding-control bit, and a residual-add enable. After that, reference rows arrive one per cycle under a valid flag, and the reconstructed rows leave one per cycle.

Every predicted pel is the rounded mean of two neighbouring reference pels. In vertical mode the two pels come from consecutive input rows, so nine rows are needed and the first row only primes the block. In horizontal mode each input row holds nine pels, and output pel i takes input pels i and i+1 of the same row. In full-pel mode the pels pass through unchanged. When the residual is enabled, a signed residual row, presented alongside the input row that produces the output, is added and the result is clamped to the 8-bit pel range.

Top module: `mc_halfpel_interp`

## Requirements
- R1: While rst_ni is low and after it rises, busy_o, out_valid_o and done_o are 0 and out_row_o is all zeros.
- R2: A start_i pulse with busy_o low captures mode_i (0 full-pel, 1 vertical, 2 horizontal, 3 treated as full-pel), rnd_i and res_en_i, and busy_o is 1 from the next cycle on. A start_i pulse with busy_o high is ignored and leaves the running block's settings unchanged.
- R3: In full-pel mode, output pel i (out_row_o bits 8i+7..8i) equals input pel i (ref_row_i bits 8i+7..8i). Eight accepted rows give eight output rows.
- R4: In vertical mode the first accepted row produces no output. Each later row r gives output row r-1, formed from the pels of rows r-1 and r in the same column. Nine accepted rows give eight output rows.
- R5: In horizontal mode each input row carries nine pels. Output pel i is formed from input pels i and i+1 of the same row. Eight accepted rows give eight output rows.
- R6: An interpolated pel equals (a + b + 1 - rnd) >> 1, where rnd is the captured rounding bit.
- R7: When the captured residual enable is 1, signed 16-bit residual pel i (res_row_i bits 16i+15..16i), sampled with the producing input row, is added to the prediction and the sum is clamped to 0..255. When the enable is 0, res_row_i has no effect.
- R8: An output row is valid in the cycle after the clock edge that accepts its input row. A cycle with ref_valid_i low produces no output row.
- R9: done_o is 1 together with the eighth output row of a block, and busy_o is 0 from that same cycle. Rows presented while busy_o is 0 produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a block and captures the settings |
| mode_i | input | 2 | Interpolation mode: 0 full, 1 vertical, 2 horizontal |
| rnd_i | input | 1 | Rounding control for the block |
| res_en_i | input | 1 | Enables residual addition for the block |
| ref_valid_i | input | 1 | ref_row_i holds a row this cycle |
| ref_row_i | input | 72 | Nine reference pels, pel i at bits 8i+7..8i |
| res_row_i | input | 128 | Eight signed residual pels, pel i at bits 16i+15..16i |
| busy_o | output | 1 | A block is accepting rows |
| out_valid_o | output | 1 | out_row_o holds a reconstructed row |
| out_row_o | output | 64 | Eight reconstructed pels |
| done_o | output | 1 | Marks the last row of a block |

## Verification
Each output row is due exactly one cycle after the edge that accepts its input row. The bench drives each row on a falling edge and, on the next falling edge, compares out_row_o, out_valid_o and done_o against a model computed from the rows it sent before it changes any input. Idle cycles inserted at random between rows are checked for the absence of out_valid_o in that same following sample. busy_o is checked one sample after start and one sample after the final row, which covers the single-cycle capture of start and the release of busy together with the last row.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    MC_FULL = 2'd0,
    MC_VERT = 2'd1,
    MC_HORZ = 2'd2,
    MC_RSVD = 2'd3
  } mc_mode_e;
endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
#(
  parameter int BLK_N = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic [1:0] mode_i,
  input  logic     rnd_i,
  input  logic     res_en_i,
  input  logic     ref_valid_i,
  output logic     busy_o,
  output logic     accept_o,
  output logic     emit_o,
  output logic     last_o,
  output mc_mode_e mode_o,
  output logic     rnd_o,
  output logic     res_en_o
);
  localparam int CNT_W = $clog2(BLK_N + 2);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  mc_mode_e         mode_q;
  logic             rnd_q, res_en_q;
  logic [CNT_W-1:0] last_idx;

  // vertical needs one extra priming row
  assign last_idx = (mode_q == MC_VERT) ? CNT_W'(BLK_N) : CNT_W'(BLK_N - 1);
  assign accept_o = busy_q && ref_valid_i;
  assign emit_o   = accept_o && !((mode_q == MC_VERT) && (cnt_q == '0));
  assign last_o   = accept_o && (cnt_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      mode_q   <= MC_FULL;
      rnd_q    <= 1'b0;
      res_en_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q   <= 1'b1;
      cnt_q    <= '0;
      mode_q   <= mc_mode_e'(mode_i);
      rnd_q    <= rnd_i;
      res_en_q <= res_en_i;
    end else if (accept_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end

  assign busy_o   = busy_q;
  assign mode_o   = mode_q;
  assign rnd_o    = rnd_q;
  assign res_en_o = res_en_q;
endmodule

// File: rtl/mc_pel_avg.sv
module mc_pel_avg #(
  parameter int PEL_W = 8
) (
  input  logic [PEL_W-1:0] a_i,
  input  logic [PEL_W-1:0] b_i,
  input  logic             rnd_i,
  output logic [PEL_W-1:0] avg_o
);
  logic [PEL_W:0] sum;
  assign sum   = {1'b0, a_i} + {1'b0, b_i} + {{PEL_W{1'b0}}, ~rnd_i};
  assign avg_o = sum[PEL_W:1];
endmodule

// File: rtl/mc_res_add.sv
module mc_res_add #(
  parameter int PEL_W = 8,
  parameter int RES_W = 16
) (
  input  logic [PEL_W-1:0] pred_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             en_i,
  output logic [PEL_W-1:0] pel_o
);
  localparam int SUM_W = RES_W + 2;
  localparam logic signed [SUM_W-1:0] PEL_MAX = SUM_W'((1 << PEL_W) - 1);

  logic signed [SUM_W-1:0] sum;
  assign sum = $signed({{(SUM_W-PEL_W){1'b0}}, pred_i})
             + $signed({{(SUM_W-RES_W){res_i[RES_W-1]}}, res_i});

  always_comb begin
    if (!en_i)             pel_o = pred_i;
    else if (sum < 0)      pel_o = '0;
    else if (sum > PEL_MAX) pel_o = '1;
    else                   pel_o = sum[PEL_W-1:0];
  end
endmodule

// File: rtl/mc_halfpel_interp.sv
module mc_halfpel_interp
  import mc_pkg::*;
#(
  parameter int BLK_N = 8,
  parameter int PEL_W = 8,
  parameter int RES_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [1:0]                 mode_i,
  input  logic                       rnd_i,
  input  logic                       res_en_i,
  input  logic                       ref_valid_i,
  input  logic [(BLK_N+1)*PEL_W-1:0] ref_row_i,
  input  logic [BLK_N*RES_W-1:0]     res_row_i,
  output logic                       busy_o,
  output logic                       out_valid_o,
  output logic [BLK_N*PEL_W-1:0]     out_row_o,
  output logic                       done_o
);
  localparam int ROW_W = BLK_N * PEL_W;

  logic     accept, emit, last;
  mc_mode_e mode;
  logic     rnd, res_en;

  mc_ctrl #(.BLK_N(BLK_N)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .rnd_i      (rnd_i),
    .res_en_i   (res_en_i),
    .ref_valid_i(ref_valid_i),
    .busy_o     (busy_o),
    .accept_o   (accept),
    .emit_o     (emit),
    .last_o     (last),
    .mode_o     (mode),
    .rnd_o      (rnd),
    .res_en_o   (res_en)
  );

  logic [ROW_W-1:0] prev_q;
  logic [ROW_W-1:0] recon;

  for (genvar i = 0; i < BLK_N; i++) begin : g_pel
    logic [PEL_W-1:0] op_a, op_b, pred;
    always_comb begin
      unique case (mode)
        MC_VERT: begin
          op_a = prev_q[i*PEL_W +: PEL_W];
          op_b = ref_row_i[i*PEL_W +: PEL_W];
        end
        MC_HORZ: begin
          op_a = ref_row_i[i*PEL_W +: PEL_W];
          op_b = ref_row_i[(i+1)*PEL_W +: PEL_W];
        end
        default: begin // full-pel: a == b averages to a for either rounding
          op_a = ref_row_i[i*PEL_W +: PEL_W];
          op_b = ref_row_i[i*PEL_W +: PEL_W];
        end
      endcase
    end

    mc_pel_avg #(.PEL_W(PEL_W)) u_avg (
      .a_i  (op_a),
      .b_i  (op_b),
      .rnd_i(rnd),
      .avg_o(pred)
    );

    mc_res_add #(.PEL_W(PEL_W), .RES_W(RES_W)) u_add (
      .pred_i(pred),
      .res_i (res_row_i[i*RES_W +: RES_W]),
      .en_i  (res_en),
      .pel_o (recon[i*PEL_W +: PEL_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      out_row_o   <= '0;
      out_valid_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      out_valid_o <= emit;
      done_o      <= last;
      if (accept) prev_q    <= ref_row_i[ROW_W-1:0];
      if (emit)   out_row_o <= recon;
    end
  end
endmodule

// File: rtl/mc_halfpel_interp_chk.sv
module mc_halfpel_interp_chk #(
  parameter int BLK_N = 8,
  parameter int PEL_W = 8,
  parameter int RES_W = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       start_i,
  input logic [1:0]                 mode_i,
  input logic                       res_en_i,
  input logic                       ref_valid_i,
  input logic [(BLK_N+1)*PEL_W-1:0] ref_row_i,
  input logic                       busy_o,
  input logic                       out_valid_o,
  input logic [BLK_N*PEL_W-1:0]     out_row_o,
  input logic                       done_o
);
  localparam int CNT_W = $clog2(BLK_N + 1);

  logic [CNT_W-1:0] vcnt_q;
  logic [1:0]       blk_mode_q;
  logic             blk_res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vcnt_q     <= '0;
      blk_mode_q <= '0;
      blk_res_q  <= 1'b0;
    end else begin
      if (start_i && !busy_o) begin
        blk_mode_q <= mode_i;
        blk_res_q  <= res_en_i;
      end
      if (done_o)           vcnt_q <= '0;
      else if (out_valid_o) vcnt_q <= vcnt_q + 1'b1;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R2
  AST_FULL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (blk_mode_q == 2'd0) && !blk_res_q
      |-> out_row_o == $past(ref_row_i[BLK_N*PEL_W-1:0])); // R3
  AST_VALID_AFTER_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(ref_valid_i) && $past(busy_o)); // R8
  AST_DONE_WITH_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> out_valid_o && !busy_o); // R9
  AST_DONE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> vcnt_q == CNT_W'(BLK_N - 1)); // R9
  AST_ROW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> vcnt_q < CNT_W'(BLK_N)); // R4
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> !out_valid_o && !done_o && !busy_o); // R1
endmodule

bind mc_halfpel_interp mc_halfpel_interp_chk #(
  .BLK_N(BLK_N), .PEL_W(PEL_W), .RES_W(RES_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .res_en_i   (res_en_i),
  .ref_valid_i(ref_valid_i),
  .ref_row_i  (ref_row_i),
  .busy_o     (busy_o),
  .out_valid_o(out_valid_o),
  .out_row_o  (out_row_o),
  .done_o     (done_o)
);

// File: tb/test_mc_halfpel_interp.sv
module test_mc_halfpel_interp;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   mode_i = '0;
  logic         rnd_i = 1'b0;
  logic         res_en_i = 1'b0;
  logic         ref_valid_i = 1'b0;
  logic [71:0]  ref_row_i = '0;
  logic [127:0] res_row_i = '0;
  logic         busy_o, out_valid_o, done_o;
  logic [63:0]  out_row_o;

  int n_chk = 0;
  int n_fail = 0;

  mc_halfpel_interp i_mc_halfpel_interp (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_row(input int md, input logic rnd, input logic ren,
                                            input logic [71:0] prv, input logic [71:0] cur,
                                            input logic [127:0] res);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      int a, b, p, s;
      a = int'(cur[i*8 +: 8]);
      if (md == 1)      b = int'(prv[i*8 +: 8]);
      else if (md == 2) b = int'(cur[(i+1)*8 +: 8]);
      else              b = a;
      p = (md == 1 || md == 2) ? (a + b + 1 - int'(rnd)) / 2 : a;
      s = ren ? p + int'($signed(res[i*16 +: 16])) : p;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      r[i*8 +: 8] = 8'(s);
    end
    return r;
  endfunction

  task automatic run_block(input int md, input logic rnd, input logic ren, input int kind);
    logic [71:0]  rows [9];
    logic [127:0] res  [8];
    int nrows;
    for (int r = 0; r < 9; r++)
      for (int i = 0; i < 9; i++) begin
        case (kind)
          1:       rows[r][i*8 +: 8] = 8'hff;
          2, 3:    rows[r][i*8 +: 8] = 8'(r * 20 + i);
          default: rows[r][i*8 +: 8] = 8'($urandom);
        endcase
      end
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 8; i++) begin
        case (kind)
          2:       res[r][i*16 +: 16] = (i == 0) ? 16'sd32767 : 16'sd300;
          3:       res[r][i*16 +: 16] = (i == 0) ? -16'sd32768 : -16'sd300;
          default: res[r][i*16 +: 16] = 16'($signed(int'($urandom % 600) - 300));
        endcase
      end
    nrows = (md == 1) ? 9 : 8;

    @(negedge clk_i);
    start_i = 1'b1; mode_i = 2'(md); rnd_i = rnd; res_en_i = ren;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R2 busy after start", 128'(busy_o), 128'd1);

    for (int r = 0; r < nrows; r++) begin
      int o;
      if ($urandom % 4 == 0) begin
        ref_valid_i = 1'b0;
        @(negedge clk_i);
        check("R8 gap gives no row", 128'(out_valid_o), 128'd0);
      end
      o = (md == 1) ? r - 1 : r;
      ref_valid_i = 1'b1;
      ref_row_i   = rows[r];
      res_row_i   = (o >= 0) ? res[o] : 128'(~0);
      if (r == 3) begin // competing start mid-block must be ignored
        start_i = 1'b1; mode_i = 2'((md + 1) % 3); rnd_i = ~rnd; res_en_i = ~ren;
      end
      @(negedge clk_i);
      start_i = 1'b0; ref_valid_i = 1'b0;
      if (o < 0) begin
        check("R4 priming row gives no output", 128'(out_valid_o), 128'd0);
      end else begin
        string tag;
        tag = (md == 1) ? "R4 R6 R7 vertical row" : (md == 2) ? "R5 R6 R7 horizontal row"
            : "R3 R7 full-pel row";
        check("R8 valid", 128'(out_valid_o), 128'd1);
        check(tag, 128'(out_row_o),
              128'(model_row(md, rnd, ren, (r > 0) ? rows[r-1] : '0, rows[r], res[o])));
        check("R9 done flag", 128'(done_o), 128'(o == 7));
      end
    end
    check("R9 busy released", 128'(busy_o), 128'd0);

    // rows while idle are ignored
    ref_valid_i = 1'b1; ref_row_i = 72'h5a;
    @(negedge clk_i);
    check("R9 idle row ignored", 128'(out_valid_o), 128'd0);
    ref_valid_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #1;
    check("R1 reset valid", 128'(out_valid_o), 128'd0);
    check("R1 reset busy", 128'(busy_o), 128'd0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset row", 128'(out_row_o), 128'd0);
    check("R1 after reset done", 128'(done_o), 128'd0);

    // directed corners
    run_block(1, 1'b0, 1'b0, 1);   // R6 max pels, round up stays 255
    run_block(2, 1'b1, 1'b0, 1);
    run_block(0, 1'b0, 1'b1, 2);   // R7 saturate high
    run_block(1, 1'b1, 1'b1, 3);   // R7 saturate low
    run_block(2, 1'b0, 1'b1, 3);
    // random mix
    for (int k = 0; k < 30; k++)
      run_block(int'($urandom % 3), 1'($urandom), 1'($urandom), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule